// File: doc/BRIEF.md
# Bus Address Selector with Deferred Latch

This block supplies the 7-bit slave address that a two-wire bus slave compares against. A board strap with three levels picks the address. The strap arrives already resolved into a 2-bit code that says low, floating or high. At power-up the address is not frozen. While the block is unlocked, the address follows the strap level as it is at that moment. The block watches the bus for transactions that open with the current address. When the second such transaction reaches its eighth SCL rising edge, the block freezes the address and raises a locked flag. From then until the next reset, the strap has no effect.

The block also cleans up SCL and SDA before use. Each line passes through a spike filter. The filter changes its output only after the raw level has held for a parameterised number of clock cycles, chosen to cover 50 ns at the system clock. The filtered lines are passed on to the rest of the slave.

Top module: `i2c_addr_sel`

## Requirements
- R1: The strap code `sel_i` decodes to these addresses:
  - 2'b00 (low) gives 7'b1001000 (0x48).
  - 2'b01 (floating) gives 7'b1001010 (0x4A).
  - 2'b10 (high) gives 7'b1001011 (0x4B).
  - The spare code 2'b11 is treated as low and gives 0x48.
- R2: While `locked_o` is 0, `addr_o` is the decode of the present `sel_i`, with no register in the path.
- R3: A valid transaction is a START followed by seven address bits, sent MSB first, that equal `addr_o` at the eighth filtered SCL rising edge. The second valid transaction freezes `addr_o` at the decode in force at that edge and sets `locked_o`. `locked_o` is registered on the (FILT_CYCLES+2)-th clock edge after the edge that first samples the raw eighth SCL high.
- R4: The following transactions do not count toward the lock:
  - a transaction whose seven address bits differ from `addr_o`;
  - a transaction cut short by STOP before the eighth SCL rising edge.
- R5: Once `locked_o` is 1, it stays 1 and `addr_o` holds its frozen value whatever `sel_i` does and whatever traffic follows.
- R6: A change on `scl_i` or `sda_i` reaches `scl_o`/`sda_o` only if the raw level holds for at least FILT_CYCLES clock edges. When it does, the output changes on the (FILT_CYCLES+1)-th edge, counted from the first edge that samples the new level. Shorter spikes never appear on the output. FILT_CYCLES = ceil(SPIKE_PS / CLK_PERIOD_PS), which is 5 by default.
- R7: Reset does three things. It clears the count of valid transactions. It clears `locked_o`, so `addr_o` again follows `sel_i`. It drives both filtered lines high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw bus clock line |
| sda_i | input | 1 | Raw bus data line |
| sel_i | input | 2 | Pre-decoded strap level (00 low, 01 floating, 10 high, 11 spare) |
| scl_o | output | 1 | Filtered bus clock |
| sda_o | output | 1 | Filtered bus data |
| addr_o | output | 7 | Active slave address |
| locked_o | output | 1 | Address has been frozen |

## Verification
Each result is due at a fixed number of cycles after its stimulus:
- A strap change shows on `addr_o` in the same cycle.
- A raw line change that holds long enough shows on the filtered line FILT_CYCLES+1 edges later.
- The lock shows FILT_CYCLES+2 edges after the raw eighth SCL rise.

The driver drives inputs on falling clock edges. Exactly when each result is due, the driver queues the expected levels of the filtered lines, the address and the flag. The monitor pops one item at every falling edge. The lock edge is therefore checked once on the cycle before it must still be low and once on the cycle it must be high. Spike rejection is checked on every cycle of a pulse one cycle shorter than the threshold.

// File: rtl/adsel_pkg.sv
package adsel_pkg;
  localparam int unsigned ADDR_W = 7;

  typedef enum logic [1:0] {
    SEL_LOW   = 2'b00,
    SEL_FLOAT = 2'b01,
    SEL_HIGH  = 2'b10,
    SEL_SPARE = 2'b11
  } sel_e;

  function automatic logic [ADDR_W-1:0] sel_to_addr(sel_e s);
    case (s)
      SEL_FLOAT: return 7'b1001010;
      SEL_HIGH:  return 7'b1001011;
      default:   return 7'b1001000;
    endcase
  endfunction
endpackage

// File: rtl/adsel_spike_filter.sv
module adsel_spike_filter #(
  parameter int unsigned FILT_CYCLES = 5,
  parameter bit          RST_VAL     = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  localparam int unsigned CW = (FILT_CYCLES < 2) ? 1 : $clog2(FILT_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(FILT_CYCLES - 1);

  logic          samp_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      samp_q <= RST_VAL;
      q_o    <= RST_VAL;
      cnt_q  <= '0;
    end else begin
      samp_q <= d_i;
      if (samp_q != q_o) begin
        if (cnt_q == LAST) begin
          q_o   <= samp_q;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;  // level fell back: restart the hold window
      end
    end
  end
endmodule

// File: rtl/adsel_frame_watch.sv
module adsel_frame_watch #(
  parameter int unsigned ADDR_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [ADDR_W-1:0] cur_addr_i,
  output logic              hit_o
);
  localparam int unsigned BW = $clog2(ADDR_W + 2);
  localparam logic [BW-1:0] LAST_ADDR = BW'(ADDR_W);

  logic              scl_q, sda_q, active_q;
  logic [BW-1:0]     bit_q;
  logic [ADDR_W-1:0] shift_q;
  logic              scl_rise, start_det, stop_det;

  assign scl_rise  = scl_i & ~scl_q;
  assign start_det = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;
  assign hit_o     = active_q & scl_rise & (bit_q == LAST_ADDR) & (shift_q == cur_addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
      active_q <= 1'b0;
      bit_q    <= '0;
      shift_q  <= '0;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
      if (start_det) begin
        active_q <= 1'b1;
        bit_q    <= '0;
      end else if (stop_det) begin
        active_q <= 1'b0;
      end else if (active_q && scl_rise) begin
        if (bit_q < LAST_ADDR) begin
          shift_q <= {shift_q[ADDR_W-2:0], sda_i};
          bit_q   <= bit_q + 1'b1;
        end else begin
          active_q <= 1'b0;  // only the first byte after START matters
        end
      end
    end
  end
endmodule

// File: rtl/i2c_addr_sel.sv
module i2c_addr_sel
  import adsel_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS = 10000,
  parameter int unsigned SPIKE_PS      = 50000,
  parameter int unsigned MATCH_COUNT   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [1:0]        sel_i,
  output logic              scl_o,
  output logic              sda_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              locked_o
);
  localparam int unsigned FILT_CYCLES = (SPIKE_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int unsigned CNT_W = $clog2(MATCH_COUNT + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MATCH_COUNT - 1);

  logic [1:0] raw_lines, filt_lines;
  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_filt
    adsel_spike_filter #(
      .FILT_CYCLES(FILT_CYCLES),
      .RST_VAL    (1'b1)
    ) u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (raw_lines[g]),
      .q_o   (filt_lines[g])
    );
  end

  assign scl_o = filt_lines[0];
  assign sda_o = filt_lines[1];

  logic [ADDR_W-1:0] live_addr, frozen_q;
  logic              hit;
  logic [CNT_W-1:0]  cnt_q;

  assign live_addr = sel_to_addr(sel_e'(sel_i));
  assign addr_o    = locked_o ? frozen_q : live_addr;

  adsel_frame_watch #(.ADDR_W(ADDR_W)) u_watch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (scl_o),
    .sda_i     (sda_o),
    .cur_addr_i(addr_o),
    .hit_o     (hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      locked_o <= 1'b0;
      frozen_q <= '0;
    end else if (hit && !locked_o) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CNT_LAST) begin
        locked_o <= 1'b1;
        frozen_q <= live_addr;
      end
    end
  end
endmodule

// File: rtl/i2c_addr_sel_chk.sv
module i2c_addr_sel_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       scl_i,
  input logic       sda_i,
  input logic [1:0] sel_i,
  input logic       scl_o,
  input logic       sda_o,
  input logic [6:0] addr_o,
  input logic       locked_o
);
  logic [6:0] strap_addr;
  always_comb begin
    strap_addr = 7'h48;
    if (sel_i == 2'b01) strap_addr = 7'h4A;
    if (sel_i == 2'b10) strap_addr = 7'h4B;
  end

  // R1, R2
  a_r2_follow_strap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !locked_o |-> addr_o == strap_addr);

  // R3
  a_r3_lock_on_scl_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> ($past(scl_o) && !$past(scl_o, 2)));

  // R5
  a_r5_lock_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o |=> locked_o);

  a_r5_addr_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_o && $past(locked_o)) |-> $stable(addr_o));

  // R6
  a_r6_scl_from_raw: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_o != $past(scl_o)) |-> scl_o == $past(scl_i, 2));

  a_r6_sda_from_raw: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_o != $past(sda_o)) |-> sda_o == $past(sda_i, 2));
endmodule

bind i2c_addr_sel i2c_addr_sel_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .scl_i   (scl_i),
  .sda_i   (sda_i),
  .sel_i   (sel_i),
  .scl_o   (scl_o),
  .sda_o   (sda_o),
  .addr_o  (addr_o),
  .locked_o(locked_o)
);

// File: tb/i2c_addr_sel_tb.sv
module i2c_addr_sel_tb;
  localparam int CLK_PERIOD = 10;
  localparam int F = 5;   // 50 ns at a 10 ns clock
  localparam int H = 20;  // bus half period in clocks
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0, rst_ni = 1'b0, scl_i = 1'b1, sda_i = 1'b1;
  logic [1:0] sel_i = 2'b01;
  logic scl_o, sda_o, locked_o;
  logic [6:0] addr_o;

  always #(CLK_PERIOD / 2) clk = ~clk;

  i2c_addr_sel u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(scl_i), .sda_i(sda_i), .sel_i(sel_i),
    .scl_o(scl_o), .sda_o(sda_o), .addr_o(addr_o), .locked_o(locked_o)
  );

  typedef struct packed {
    logic       scl;
    logic       sda;
    logic [6:0] addr;
    logic       lk;
  } exp_t;

  exp_t  sb_q[$];
  string tag_q[$];
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  function automatic logic [6:0] dec(input logic [1:0] s);
    case (s)
      2'b01:   return 7'h4A;
      2'b10:   return 7'h4B;
      default: return 7'h48;
    endcase
  endfunction

  // monitor: one expected item per falling edge
  initial forever begin
    @(negedge clk);
    if (sb_q.size() > 0) begin
      exp_t e;
      string t;
      e = sb_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if ({scl_o, sda_o, addr_o, locked_o} !== e) begin
        n_bad++;
        $display("FAIL %s: got scl=%b sda=%b addr=%h lk=%b, exp scl=%b sda=%b addr=%h lk=%b",
                 t, scl_o, sda_o, addr_o, locked_o, e.scl, e.sda, e.addr, e.lk);
      end
    end
  end

  task automatic chk(input logic s, input logic d, input logic [6:0] a,
                     input logic l, input string t);
    sb_q.push_back('{scl: s, sda: d, addr: a, lk: l});
    tag_q.push_back(t);
    @(negedge clk);
  endtask

  task automatic half();
    repeat (H) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_i = 1; scl_i = 1; half();
    sda_i = 0; half();
    scl_i = 0; half();
  endtask

  task automatic put_bit(input logic b);
    sda_i = b; half();
    scl_i = 1; half();
    scl_i = 0;
  endtask

  task automatic bus_stop();
    sda_i = 0; half();
    scl_i = 1; half();
    sda_i = 1; half();
    repeat (F + 4) @(negedge clk);
  endtask

  // nb < 8 aborts with STOP after nb address bits
  task automatic frame(input logic [6:0] a, input int nb, input logic [6:0] ea,
                       input logic lk0, input logic lk1, input string t);
    bus_start();
    for (int i = 0; i < nb && i < 7; i++) put_bit(a[6 - i]);
    if (nb >= 8) begin
      sda_i = 0; half();
      scl_i = 1;
      repeat (F) @(negedge clk);
      chk(1, 0, ea, lk0, t);  // F+1 edges: no lock yet
      chk(1, 0, ea, lk1, t);  // F+2 edges: lock due
      repeat (H - F - 2) @(negedge clk);
      scl_i = 0;
      put_bit(1);
    end
    bus_stop();
    chk(1, 1, ea, lk1, t);
  endtask

  initial begin
    int wd = 0;
    while (!done && wd < WATCHDOG) begin
      @(posedge clk);
      wd++;
    end
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout, exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(1, 1, 7'h4A, 0, "R7 reset state");
    rst_ni = 1;
    @(negedge clk);

    // R1/R2 decode and follow
    sel_i = 2'b10; chk(1, 1, 7'h4B, 0, "R2 strap follows");
    sel_i = 2'b11; chk(1, 1, 7'h48, 0, "R1 spare code");
    sel_i = 2'b00; chk(1, 1, 7'h48, 0, "R1 low");
    sel_i = 2'b01; chk(1, 1, 7'h4A, 0, "R1 float");

    // R6 short spike on scl rejected
    scl_i = 0;
    for (int j = 0; j < F - 1; j++) chk(1, 1, 7'h4A, 0, "R6 short scl spike");
    scl_i = 1;
    for (int j = 0; j < F + 2; j++) chk(1, 1, 7'h4A, 0, "R6 short scl spike");

    // R6 pulse of exactly F passes after F+1 edges
    scl_i = 0;
    for (int j = 0; j < F; j++) chk(1, 1, 7'h4A, 0, "R6 scl held");
    scl_i = 1;
    chk(0, 1, 7'h4A, 0, "R6 scl edge timing");
    repeat (F + 4) @(negedge clk);
    chk(1, 1, 7'h4A, 0, "R6 scl restored");

    // R6 short spike on sda with scl low
    scl_i = 0;
    repeat (F + 4) @(negedge clk);
    sda_i = 0;
    for (int j = 0; j < F - 1; j++) chk(0, 1, 7'h4A, 0, "R6 short sda spike");
    sda_i = 1;
    for (int j = 0; j < F + 2; j++) chk(0, 1, 7'h4A, 0, "R6 short sda spike");
    scl_i = 1;
    repeat (F + 4) @(negedge clk);

    // R4: mismatch and aborted frames do not count
    sel_i = 2'b10;
    frame(7'h48, 8, 7'h4B, 0, 0, "R4 mismatched address");
    frame(7'h4B, 5, 7'h4B, 0, 0, "R4 aborted frame");
    frame(7'h4B, 5, 7'h4B, 0, 0, "R4 aborted frame");
    frame(7'h4B, 8, 7'h4B, 0, 0, "R3 first valid");
    // R3: second valid with a new strap level locks that level
    sel_i = 2'b00;
    chk(1, 1, 7'h48, 0, "R2 strap follows");
    frame(7'h48, 8, 7'h48, 0, 1, "R3 second valid locks");

    // R5: strap ignored after lock
    sel_i = 2'b10; chk(1, 1, 7'h48, 1, "R5 strap ignored");
    sel_i = 2'b01; chk(1, 1, 7'h48, 1, "R5 strap ignored");
    frame(7'h48, 8, 7'h48, 1, 1, "R5 traffic after lock");

    // R7: reset clears lock and counter
    rst_ni = 0;
    @(negedge clk);
    chk(1, 1, dec(2'b01), 0, "R7 reset clears lock");
    rst_ni = 1;
    sel_i = 2'b10;
    chk(1, 1, 7'h4B, 0, "R7 strap follows after reset");
    frame(7'h4B, 8, 7'h4B, 0, 0, "R7 counter cleared");

    wait (sb_q.size() == 0);
    @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule